// File: doc/BRIEF.md
# Lane Alignment Character Restorer and Link Monitor

This unit sits on one receive lane of a multi-lane serial converter link, after the 8b/10b decoder. Each clock it takes one decoded octet with its control flag, the decoder's disparity and invalid-code flags, and two position strobes from a frame counter shared by all lanes: the last octet of a frame and the last octet of a multiframe. The transmitter puts an alignment control character where a data octet would repeat the previous one. This unit puts the stored previous data octet back in its place, so the data stream leaves one cycle later with nothing lost.

Because every lane is checked against the same shared position strobes, an alignment character that turns up anywhere but its expected slot shows this lane has slipped against the others. Such events, unexpected control characters and decoder errors are each counted in their own saturating counter, which a clear pulse resets. Misalignments only request re-synchronisation after a programmable number of occurrences, or never. The other error kinds request it at once if their enable bit is set. A request drives the active-low sync output low for one whole frame.

Top module: `lane_align_monitor`

## Requirements
- R1: A decoded octet with the control flag clear and no invalid-code flag appears on `out_octet` one cycle later, unchanged, with `out_is_k` low.
- R2: A control octet 0xFC that arrives with `pos_frame_end` high and `pos_mf_end` low is replaced on the output by the most recent data octet sent out (0x00 if none since reset), with `out_is_k` low. The replacement value stays the stored one.
- R3: A control octet 0x7C that arrives with `pos_mf_end` high is replaced in the same way as in R2.
- R4: A control octet 0xFC with `pos_frame_end` low or `pos_mf_end` high, or a control octet 0x7C with `pos_mf_end` low, adds one to `cnt_mis` and passes through unchanged with `out_is_k` high.
- R5: Any other control octet adds one to `cnt_ctrl` and passes through unchanged with `out_is_k` high.
- R6: `rx_err_disp` adds one to `cnt_disp`. `rx_err_nit` adds one to `cnt_nit`, and that octet passes through raw, is never replaced and is never stored as the previous data octet.
- R7: Every counter stops at its maximum value, 2^CNT_W-1.
- R8: A `cnt_clr` pulse sets all four counters and the misalignment tally to zero on the next cycle. The clear wins over an event in the same cycle.
- R9: With `cfg_mis_tol` = 0, misalignments never pull sync low. With a value N from 1 up, the Nth misalignment counted since the last request or clear starts a request.
- R10: `cfg_resync_en` bit 0 (disparity), bit 1 (invalid code) and bit 2 (unexpected control) each make that error start a request at once. A cleared bit means that error never starts one.
- R11: A request drives `sync_n` low from the cycle after the triggering octet for `cfg_frame_len` cycles (0 counts as 1), then high. Events while `sync_n` is low start no request and add nothing to the tally.
- R12: After reset, `sync_n` is high and all counters and `out_octet` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_octet | input | 8 | Decoded octet |
| rx_is_k | input | 1 | Octet is a control character |
| rx_err_disp | input | 1 | Running-disparity error from decoder |
| rx_err_nit | input | 1 | Code not in decode table |
| pos_frame_end | input | 1 | Octet is the last of a frame |
| pos_mf_end | input | 1 | Octet is the last of a multiframe |
| cfg_mis_tol | input | TOL_W | Misalignments before a request; 0 = never |
| cfg_resync_en | input | 3 | Request enables: disparity, invalid code, control |
| cfg_frame_len | input | F_W | Octets per frame; sets sync low duration |
| cnt_clr | input | 1 | Clear counters and tally |
| out_octet | output | 8 | Restored octet |
| out_is_k | output | 1 | Restored octet is a control character |
| cnt_disp | output | CNT_W | Disparity error count |
| cnt_nit | output | CNT_W | Invalid-code count |
| cnt_ctrl | output | CNT_W | Unexpected control count |
| cnt_mis | output | CNT_W | Misalignment count |
| sync_n | output | 1 | Active-low re-synchronisation request |

## Verification
The bench sends a second 0xFC after a replacement. A design that stored the alignment character as the previous octet would then send out 0xFC in place of the data value. It marks an octet invalid just before an alignment character, which catches a design that stores decoder garbage. It also places a misalignment while sync is held low and then another after release. A design that counts events during the hold would trip early with tolerance 2. The bench also covers the one-cycle hold for a zero frame length, the tally clear, the clear-over-increment rule and counter saturation after 260 events. Each of these would show up as a wrong octet, an early or missing sync pulse, or a counter that wraps.

// File: rtl/lam_pkg.sv
package lam_pkg;
    localparam int OCT_W = 8;
    localparam logic [OCT_W-1:0] K_FRAME_ALIGN = 8'hFC;
    localparam logic [OCT_W-1:0] K_MF_ALIGN    = 8'h7C;
    localparam int N_ERR = 4;
    // error index order used by counter array
    localparam int E_DISP = 0;
    localparam int E_NIT  = 1;
    localparam int E_CTRL = 2;
    localparam int E_MIS  = 3;

    typedef struct packed {
        logic [OCT_W-1:0] out_octet;
        logic             out_is_k;
        logic [OCT_W-1:0] prev;
    } lam_path_t;
endpackage

// File: rtl/lam_classify.sv
module lam_classify
    import lam_pkg::*;
(
    input  logic [OCT_W-1:0] octet,
    input  logic             is_k,
    input  logic             nit,
    input  logic             frame_end,
    input  logic             mf_end,
    output logic             replace,
    output logic             ctrl_err,
    output logic             mis_err
);
    always_comb begin
        replace  = 1'b0;
        ctrl_err = 1'b0;
        mis_err  = 1'b0;
        if (is_k && !nit) begin
            if (octet == K_FRAME_ALIGN) begin
                if (frame_end && !mf_end) replace = 1'b1;
                else                      mis_err = 1'b1;
            end else if (octet == K_MF_ALIGN) begin
                if (mf_end) replace = 1'b1;
                else        mis_err = 1'b1;
            end else begin
                ctrl_err = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lam_sat_counter.sv
module lam_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (inc && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_cnt_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !clr) |=> cnt_q == MAXV);
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/lam_resync_ctrl.sv
module lam_resync_ctrl #(
    parameter int TOL_W = 2,
    parameter int F_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mis_evt,
    input  logic             hard_evt,
    input  logic [TOL_W-1:0] cfg_tol,
    input  logic [F_W-1:0]   cfg_frame_len,
    output logic             sync_n
);
    typedef struct packed {
        logic             sync_n;
        logic [F_W-1:0]   hold;
        logic [TOL_W-1:0] tally;
    } rs_state_t;

    rs_state_t st_d, st_q;
    logic      tol_on, mis_trip;

    always_comb begin
        st_d     = st_q;
        tol_on   = (cfg_tol != '0);
        mis_trip = mis_evt && tol_on &&
                   (({1'b0, st_q.tally} + 1'b1) == {1'b0, cfg_tol});
        if (!st_q.sync_n) begin
            if (st_q.hold == '0) st_d.sync_n = 1'b1;
            else                 st_d.hold   = st_q.hold - 1'b1;
        end else if (hard_evt || mis_trip) begin
            st_d.sync_n = 1'b0;
            st_d.hold   = (cfg_frame_len == '0) ? '0 : cfg_frame_len - 1'b1;
            st_d.tally  = '0;
        end else if (mis_evt && tol_on) begin
            st_d.tally = st_q.tally + 1'b1;
        end
        if (clr) st_d.tally = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sync_n: 1'b1, hold: '0, tally: '0};
        else        st_q <= st_d;
    end

    assign sync_n = st_q.sync_n;

    assert_hold_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && st_q.hold != '0) |=> !sync_n);
    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && st_q.hold == '0) |=> sync_n);
    assert_tol_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && cfg_tol == '0 && !hard_evt) |=> sync_n);
endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor
    import lam_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TOL_W = 2,
    parameter int F_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_octet,
    input  logic             rx_is_k,
    input  logic             rx_err_disp,
    input  logic             rx_err_nit,
    input  logic             pos_frame_end,
    input  logic             pos_mf_end,
    input  logic [TOL_W-1:0] cfg_mis_tol,
    input  logic [2:0]       cfg_resync_en,
    input  logic [F_W-1:0]   cfg_frame_len,
    input  logic             cnt_clr,
    output logic [7:0]       out_octet,
    output logic             out_is_k,
    output logic [CNT_W-1:0] cnt_disp,
    output logic [CNT_W-1:0] cnt_nit,
    output logic [CNT_W-1:0] cnt_ctrl,
    output logic [CNT_W-1:0] cnt_mis,
    output logic             sync_n
);
    logic              replace, ctrl_err, mis_err, hard_evt;
    logic [N_ERR-1:0]  err_vec;
    logic [CNT_W-1:0]  cnt_arr [N_ERR];
    lam_path_t         path_d, path_q;

    lam_classify u_cls (
        .octet     (rx_octet),
        .is_k      (rx_is_k),
        .nit       (rx_err_nit),
        .frame_end (pos_frame_end),
        .mf_end    (pos_mf_end),
        .replace   (replace),
        .ctrl_err  (ctrl_err),
        .mis_err   (mis_err)
    );

    always_comb begin
        err_vec         = '0;
        err_vec[E_DISP] = rx_err_disp;
        err_vec[E_NIT]  = rx_err_nit;
        err_vec[E_CTRL] = ctrl_err;
        err_vec[E_MIS]  = mis_err;
        hard_evt = |(cfg_resync_en & {ctrl_err, rx_err_nit, rx_err_disp});
    end

    // restore path
    always_comb begin
        path_d = path_q;
        if (replace) begin
            path_d.out_octet = path_q.prev;
            path_d.out_is_k  = 1'b0;
        end else begin
            path_d.out_octet = rx_octet;
            path_d.out_is_k  = rx_is_k;
            if (!rx_is_k && !rx_err_nit) path_d.prev = rx_octet;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    assign out_octet = path_q.out_octet;
    assign out_is_k  = path_q.out_is_k;

    for (genvar g = 0; g < N_ERR; g++) begin : g_cnt
        lam_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (err_vec[g]),
            .count (cnt_arr[g])
        );
    end

    assign cnt_disp = cnt_arr[E_DISP];
    assign cnt_nit  = cnt_arr[E_NIT];
    assign cnt_ctrl = cnt_arr[E_CTRL];
    assign cnt_mis  = cnt_arr[E_MIS];

    lam_resync_ctrl #(.TOL_W(TOL_W), .F_W(F_W)) u_rs (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (cnt_clr),
        .mis_evt       (mis_err),
        .hard_evt      (hard_evt),
        .cfg_tol       (cfg_mis_tol),
        .cfg_frame_len (cfg_frame_len),
        .sync_n        (sync_n)
    );

    assert_data_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_is_k && !rx_err_nit) |=> (out_octet == $past(rx_octet) && !out_is_k));
    assert_frame_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_is_k && !rx_err_nit && rx_octet == K_FRAME_ALIGN && pos_frame_end && !pos_mf_end)
        |=> (out_octet == $past(path_q.prev) && !out_is_k));
    assert_mf_replace_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_is_k && !rx_err_nit && rx_octet == K_MF_ALIGN && pos_mf_end)
        |=> (out_octet == $past(path_q.prev) && !out_is_k));
    assert_k_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_is_k && (rx_err_nit || (rx_octet != K_FRAME_ALIGN && rx_octet != K_MF_ALIGN)))
        |=> (out_octet == $past(rx_octet) && out_is_k));
endmodule

// File: tb/lane_align_monitor_test.sv
module lane_align_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       rx_octet = '0;
    logic             rx_is_k = 1'b0, rx_err_disp = 1'b0, rx_err_nit = 1'b0;
    logic             pos_frame_end = 1'b0, pos_mf_end = 1'b0;
    logic [1:0]       cfg_mis_tol = '0;
    logic [2:0]       cfg_resync_en = '0;
    logic [7:0]       cfg_frame_len = 8'd1;
    logic             cnt_clr = 1'b0;
    logic [7:0]       out_octet;
    logic             out_is_k;
    logic [CNT_W-1:0] cnt_disp, cnt_nit, cnt_ctrl, cnt_mis;
    logic             sync_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_align_monitor #(.CNT_W(CNT_W), .TOL_W(2), .F_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_octet(rx_octet), .rx_is_k(rx_is_k),
        .rx_err_disp(rx_err_disp), .rx_err_nit(rx_err_nit),
        .pos_frame_end(pos_frame_end), .pos_mf_end(pos_mf_end),
        .cfg_mis_tol(cfg_mis_tol), .cfg_resync_en(cfg_resync_en),
        .cfg_frame_len(cfg_frame_len), .cnt_clr(cnt_clr),
        .out_octet(out_octet), .out_is_k(out_is_k),
        .cnt_disp(cnt_disp), .cnt_nit(cnt_nit), .cnt_ctrl(cnt_ctrl),
        .cnt_mis(cnt_mis), .sync_n(sync_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one octet at a falling edge; returns after the next falling edge
    task automatic step(input logic [7:0] o, input logic k, input logic fe, input logic me,
                        input logic disp, input logic nit, input logic clr);
        rx_octet = o; rx_is_k = k; pos_frame_end = fe; pos_mf_end = me;
        rx_err_disp = disp; rx_err_nit = nit; cnt_clr = clr;
        @(negedge clk);
        rx_is_k = 1'b0; pos_frame_end = 1'b0; pos_mf_end = 1'b0;
        rx_err_disp = 1'b0; rx_err_nit = 1'b0; cnt_clr = 1'b0;
    endtask

    task automatic data(input logic [7:0] o);
        step(o, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        check("R12 sync_n", sync_n, 1);
        check("R12 out_octet", out_octet, 0);
        check("R12 counters", {cnt_disp, cnt_nit, cnt_ctrl, cnt_mis}, 0);
    endtask

    task automatic t_pass;
        data(8'h12);
        check("R1 octet", out_octet, 8'h12);
        check("R1 k", out_is_k, 0);
        data(8'h34);
        check("R1 octet2", out_octet, 8'h34);
    endtask

    task automatic t_frame_replace;
        data(8'h5A);
        step(8'hFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 replaced", out_octet, 8'h5A);
        check("R2 k cleared", out_is_k, 0);
        step(8'hFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 repeat keeps value", out_octet, 8'h5A);
        check("R2 no mis", cnt_mis, 0);
    endtask

    task automatic t_mf_replace;
        data(8'hC3);
        step(8'h7C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 replaced", {out_is_k, out_octet}, {1'b0, 8'hC3});
    endtask

    task automatic t_misalign;
        cfg_mis_tol = 2'd0;
        step(8'hFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 pass fc", {out_is_k, out_octet}, {1'b1, 8'hFC});
        check("R4 cnt 1", cnt_mis, 1);
        step(8'h7C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 pass 7c", {out_is_k, out_octet}, {1'b1, 8'h7C});
        step(8'hFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 cnt 3", cnt_mis, 3);
        check("R9 tol0 no sync", sync_n, 1);
    endtask

    task automatic t_ctrl;
        cfg_resync_en = 3'b000;
        step(8'hBC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 pass", {out_is_k, out_octet}, {1'b1, 8'hBC});
        check("R5 cnt", cnt_ctrl, 1);
        check("R10 disabled no sync", sync_n, 1);
    endtask

    task automatic t_dec_err;
        step(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 disp cnt", cnt_disp, 1);
        check("R6 disp octet", out_octet, 8'h22);
        step(8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 nit cnt", cnt_nit, 1);
        step(8'hFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 nit not replaced", {out_is_k, out_octet}, {1'b1, 8'hFC});
        check("R6 nit not misalign", cnt_mis, 3);
        step(8'hFC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 nit not stored", out_octet, 8'h22);
    endtask

    task automatic t_clear;
        step(8'hBC, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R8 clear wins", {cnt_disp, cnt_nit, cnt_ctrl, cnt_mis}, 0);
    endtask

    task automatic t_tolerance;
        cfg_mis_tol = 2'd2; cfg_frame_len = 8'd3;
        step(8'hFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 first no sync", sync_n, 1);
        step(8'hFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 second sync low", sync_n, 0);
        step(8'h7C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 low cycle 2", sync_n, 0);
        data(8'h01);
        check("R11 low cycle 3", sync_n, 0);
        data(8'h02);
        check("R11 released", sync_n, 1);
        step(8'hFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 hold events ignored", sync_n, 1);
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'hFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 tally cleared", sync_n, 1);
        cfg_mis_tol = 2'd0;
    endtask

    task automatic t_enable;
        cfg_resync_en = 3'b100; cfg_frame_len = 8'd0;
        step(8'hBC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10 ctrl enabled sync", sync_n, 0);
        data(8'h03);
        check("R11 zero len one cycle", sync_n, 1);
        cfg_resync_en = 3'b001; cfg_frame_len = 8'd1;
        step(8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 disp enabled sync", sync_n, 0);
        data(8'h05);
        cfg_resync_en = 3'b000;
    endtask

    task automatic t_saturate;
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 260; i++) step(8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 saturate", cnt_disp, 255);
        check("R7 others untouched", cnt_nit, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_pass;
        t_frame_replace;
        t_mf_replace;
        t_misalign;
        t_ctrl;
        t_dec_err;
        t_clear;
        t_tolerance;
        t_enable;
        t_saturate;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule